// File: doc/BRIEF.md
# Carrier Sense Hysteresis Filter

This block takes one comparison bit per sample: is the sample's level at or above the carrier-sense threshold? It turns that stream into a debounced carrier-present flag. The flag rises only after a programmable number of consecutive qualifying samples. It falls only after a separately programmable number of consecutive samples below the threshold. The two directions therefore have independent hysteresis.

The assert run length is chosen by a 2-bit code and the clear run length by a 1-bit code. A longer assert run suppresses false indications caused by noise, at the cost of a slower response.

Samples arrive as a valid-qualified stream. The filter accepts every sample in the cycle its valid strobe is high and never applies back-pressure, so it has no ready output. The flag is registered and can drive an external indicator pin directly.

Top module: `cs_hyst_filter`

## Requirements
- R1: With set code `s` (0..3), the flag rises after exactly `s+1` consecutive accepted samples with `smp_above=1`. It reads high in the cycle after the edge that accepted the last of those samples.
- R2: With clear code `c` (0..1), the flag falls after exactly `c+1` consecutive accepted samples with `smp_above=0`. It reads low in the cycle after the edge that accepted the last of those samples.
- R3: An accepted below-threshold sample restarts the above-threshold run from zero. An accepted above-threshold sample restarts the below-threshold run from zero.
- R4: On a cycle where `smp_valid=0`, the flag and both run counts keep their values, whatever `smp_above` and the codes are doing.
- R5: A long unbroken run in either direction keeps the flag steady, and the run counts saturate rather than wrap. After any number of extra above samples, a single below sample with clear code 0 still clears the flag, and a new run of `s+1` above samples is still needed to set it again.
- R6: A synchronous reset clears the flag and both run counts, and it takes priority over a sample accepted in the same cycle.
- R7: A change to either code applies to the next accepted sample. That sample's updated run count is compared against the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; the sample is accepted on this clock edge |
| smp_above | input | 1 | 1 = sample at or above threshold, 0 = below |
| set_code | input | 2 | Assert run length minus one |
| clr_code | input | 1 | Clear run length minus one |
| carrier_flag | output | 1 | Registered, debounced carrier-present flag |

## Verification
Two pairs of events can meet in one cycle. A code change can arrive together with the sample that completes a run. A reset can arrive together with an accepted sample. The bench provokes the first by switching the code in the same cycle as that sample, both in directed cases and at random. It provokes the second with a directed reset-plus-sample cycle. Each case is judged against a bench reference model, which applies the code presented with the sample and lets reset win.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Widths of the run-length codes
  localparam int SET_CODE_W = 2;
  localparam int CLR_CODE_W = 1;

  // Longest run each code can request
  localparam int SET_MAX = 1 << SET_CODE_W;
  localparam int CLR_MAX = 1 << CLR_CODE_W;

  // Counter widths large enough to hold the saturated run
  localparam int SET_CNT_W = $clog2(SET_MAX + 1);
  localparam int CLR_CNT_W = $clog2(CLR_MAX + 1);

  typedef logic [SET_CNT_W-1:0] set_cnt_t;
  typedef logic [CLR_CNT_W-1:0] clr_cnt_t;
endpackage

// File: rtl/cs_need_decode.sv
// Maps a run-length code to the required run: code + 1.
module cs_need_decode #(
  parameter int CODE_W = 2,
  parameter int NEED_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [NEED_W-1:0] need
);
  always_comb begin
    need = NEED_W'(code) + NEED_W'(1);
  end
endmodule

// File: rtl/cs_run_counter.sv
// Saturating consecutive-sample counter with restart.
module cs_run_counter #(
  parameter int MAX_RUN = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RUN);

  always_comb begin
    if (cnt_q >= LIMIT) cnt_nx = LIMIT;
    else                cnt_nx = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (adv)     cnt_q <= cnt_nx;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R5

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !restart) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/cs_flag_ctrl.sv
// Decides the flag from the post-sample run counts and the required runs.
module cs_flag_ctrl #(
  parameter int SET_W = 3,
  parameter int CLR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic             smp_above,
  input  logic [SET_W-1:0] set_run_nx,
  input  logic [SET_W-1:0] set_need,
  input  logic [CLR_W-1:0] clr_run_nx,
  input  logic [CLR_W-1:0] clr_need,
  output logic             flag_q
);
  logic hit_set;
  logic hit_clr;

  always_comb begin
    hit_set = smp_valid &&  smp_above && (set_run_nx >= set_need);
    hit_clr = smp_valid && !smp_above && (clr_run_nx >= clr_need);
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (hit_set) flag_q <= 1'b1;
    else if (hit_clr) flag_q <= 1'b0;
  end

  AST_RISE_NEEDS_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(smp_valid && smp_above)) |=> !flag_q); // R1

  AST_FALL_NEEDS_BELOW: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(smp_valid && !smp_above)) |=> flag_q); // R2

  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(flag_q)); // R4
endmodule

// File: rtl/cs_hyst_filter.sv
module cs_hyst_filter
  import cs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_valid,
  input  logic                  smp_above,
  input  logic [SET_CODE_W-1:0] set_code,
  input  logic [CLR_CODE_W-1:0] clr_code,
  output logic                  carrier_flag
);
  set_cnt_t set_need, set_run_q, set_run_nx;
  clr_cnt_t clr_need, clr_run_q, clr_run_nx;
  logic     take_hi, take_lo;

  always_comb begin
    take_hi = smp_valid &&  smp_above;
    take_lo = smp_valid && !smp_above;
  end

  cs_need_decode #(.CODE_W(SET_CODE_W), .NEED_W(SET_CNT_W)) u_set_dec (
    .code(set_code), .need(set_need));

  cs_need_decode #(.CODE_W(CLR_CODE_W), .NEED_W(CLR_CNT_W)) u_clr_dec (
    .code(clr_code), .need(clr_need));

  cs_run_counter #(.MAX_RUN(SET_MAX), .CNT_W(SET_CNT_W)) u_set_run (
    .clk(clk), .rst(rst), .adv(take_hi), .restart(take_lo),
    .cnt_q(set_run_q), .cnt_nx(set_run_nx));

  cs_run_counter #(.MAX_RUN(CLR_MAX), .CNT_W(CLR_CNT_W)) u_clr_run (
    .clk(clk), .rst(rst), .adv(take_lo), .restart(take_hi),
    .cnt_q(clr_run_q), .cnt_nx(clr_run_nx));

  cs_flag_ctrl #(.SET_W(SET_CNT_W), .CLR_W(CLR_CNT_W)) u_flag (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_above(smp_above),
    .set_run_nx(set_run_nx), .set_need(set_need),
    .clr_run_nx(clr_run_nx), .clr_need(clr_need),
    .flag_q(carrier_flag));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!carrier_flag && set_run_q == '0 && clr_run_q == '0)); // R6

  AST_RUNS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(set_run_q != '0 && clr_run_q != '0)); // R3
endmodule

// File: tb/cs_hyst_filter_tb.sv
module cs_hyst_filter_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       smp_valid;
  logic       smp_above;
  logic [1:0] set_code;
  logic [0:0] clr_code;
  logic       carrier_flag;

  int checks = 0;
  int errors = 0;
  int m_hi, m_lo;
  bit m_flag;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cs_hyst_filter u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_above(smp_above),
    .set_code(set_code), .clr_code(clr_code), .carrier_flag(carrier_flag));

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic check(input string req, input bit exp);
    checks++;
    if (carrier_flag !== exp) begin
      errors++;
      $display("FAIL %s flag=%0b expected=%0b t=%0t", req, carrier_flag, exp, $time);
    end
  endtask

  // Drive one cycle, update the reference model and compare.
  task automatic step(input bit r, input bit v, input bit a,
                      input int sc, input int cc, input string req);
    rst = r; smp_valid = v; smp_above = a;
    set_code = 2'(sc); clr_code = 1'(cc);
    @(posedge clk);
    if (r) begin
      m_hi = 0; m_lo = 0; m_flag = 0;
    end else if (v && a) begin
      m_hi = sat(m_hi + 1, 4); m_lo = 0;
      if (m_hi >= sc + 1) m_flag = 1;
    end else if (v) begin
      m_lo = sat(m_lo + 1, 2); m_hi = 0;
      if (m_lo >= cc + 1) m_flag = 0;
    end
    @(negedge clk);
    check(req, m_flag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; smp_valid = 0; smp_above = 0; set_code = 1; clr_code = 1;
    m_hi = 0; m_lo = 0; m_flag = 0;
    @(negedge clk);
    step(1, 0, 0, 1, 1, "R6");
    step(1, 0, 0, 1, 1, "R6");

    // R1: each set code needs exactly code+1 samples
    for (int s = 0; s < 4; s++) begin
      step(1, 0, 0, s, 0, "R6");
      for (int k = 0; k <= s; k++) step(0, 1, 1, s, 0, "R1");
    end

    // R2: each clear code needs exactly code+1 samples
    for (int c = 0; c < 2; c++) begin
      step(0, 1, 1, 0, c, "R1");
      for (int k = 0; k <= c; k++) step(0, 1, 0, 0, c, "R2");
    end

    // R3: interrupted runs restart
    step(0, 1, 1, 2, 1, "R3"); step(0, 1, 1, 2, 1, "R3");
    step(0, 1, 0, 2, 1, "R3");
    step(0, 1, 1, 2, 1, "R3"); step(0, 1, 1, 2, 1, "R3");
    step(0, 1, 1, 2, 1, "R3");
    step(0, 1, 0, 2, 1, "R3"); step(0, 1, 1, 2, 1, "R3");
    step(0, 1, 0, 2, 1, "R3"); step(0, 1, 0, 2, 1, "R3");

    // R4: no strobe, no change
    for (int k = 0; k < 6; k++) step(0, 0, 1, 0, 0, "R4");
    step(0, 1, 1, 0, 0, "R4");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, "R4");

    // R5: long run saturates, then clears in one and needs full run to set
    for (int k = 0; k < 20; k++) step(0, 1, 1, 3, 0, "R5");
    step(0, 1, 0, 3, 0, "R5");
    for (int k = 0; k < 4; k++) step(0, 1, 1, 3, 0, "R5");
    for (int k = 0; k < 9; k++) step(0, 1, 0, 3, 1, "R5");

    // R6: reset beats a completing sample
    step(0, 1, 1, 1, 1, "R6");
    step(1, 1, 1, 1, 1, "R6");
    step(0, 1, 1, 1, 1, "R6");

    // R7: code change applied with the completing sample
    step(1, 0, 0, 3, 1, "R6");
    step(0, 1, 1, 3, 1, "R7"); step(0, 1, 1, 3, 1, "R7");
    step(0, 1, 1, 1, 1, "R7");
    step(0, 1, 0, 1, 1, "R7");
    step(0, 1, 0, 1, 0, "R7");

    // Random mix, fixed seed
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      automatic int r = $urandom_range(0, 199);
      step(r == 0, $urandom_range(0, 3) != 0, $urandom_range(0, 9) < 6,
           (k % 37 == 0) ? $urandom_range(0, 3) : (k / 37) % 4,
           (k % 23 == 0) ? $urandom_range(0, 1) : (k / 23) % 2, "R7");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule